// File: doc/BRIEF.md
# Self-Timed DRAM Refresh Engine

This block keeps an asynchronous DRAM alive by issuing CAS-before-RAS refresh cycles at a fixed rate. A free-running timer marks each refresh slot. With the default of 1953 clocks at 125 MHz, one slot falls roughly every 15.6 µs, so 1024 refreshes fit in a 16 ms retention window. Every slot adds one to a small saturating count of owed refreshes. While anything is owed, or while a refresh is in progress, the block raises a request toward the memory arbiter.

When the arbiter grants the bus, the block lowers the column strobe first and then the row strobe. It holds them for configurable counts, returns both strobes high and waits out the precharge time before it drops its request. The device steps its own internal row counter on each such cycle. The block therefore never drives an address and never drives the data bus. It keeps the write enable and the output enable inactive for the whole cycle.

If refreshes are owed and the grant is still held at the end of a precharge, the next refresh follows at once. This lets a long page burst delay refresh for several slots and then catch up in one run.

Top module: `cbr_refresh_sched`

## Requirements
- R1: During and right after a synchronous reset, the outputs are as follows: `ras_n`, `cas_n`, `we_n` and `oe_n` are 1, and `req` is 0.
- R2: While `grant` stays high, each refresh starts with `cas_n` falling. This is first seen in clock k*INTERVAL+2 after reset is released, for k = 1, 2, and so on.
- R3: A refresh starts in the clock after `req` and `grant` are both sampled high. `req` stays high from then until the refresh's precharge is complete.
- R4: `cas_n` is low on its own for exactly T_SETUP clocks before `ras_n` falls. `ras_n` never falls while `cas_n` is high.
- R5: `ras_n` stays low for exactly T_RAS clocks. `cas_n` returns high T_CHOLD clocks after `ras_n` falls, where 1 <= T_CHOLD < T_RAS.
- R6: After `ras_n` rises, both strobes stay high for at least T_RP clocks before the next refresh. For a single refresh, `req` falls T_SETUP+T_RAS+T_RP clocks after `cas_n` fell.
- R7: `we_n` and `oe_n` are held at 1 in every clock.
- R8: The count of owed refreshes saturates at MAX_OWED. Slots that arrive while the count is full are dropped.
- R9: While `grant` is held, owed refreshes are issued back to back. Consecutive `cas_n` falls are then T_SETUP+T_RAS+T_RP clocks apart.
- R10: Dropping `grant` during a refresh does not shorten or abort that refresh. `req` stays high until the refresh finishes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant | input | 1 | Bus granted to the refresh engine by the arbiter |
| req | output | 1 | Refresh engine wants or holds the bus |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held inactive |
| oe_n | output | 1 | Output enable, held inactive |

## Verification
A slot tick is registered one clock after the timer wraps. The owed count and `req` update on the next clock. With `grant` already high, `cas_n` falls on the clock after that, so each start is due at k*INTERVAL+2. From that start, `ras_n` falls after T_SETUP clocks, `cas_n` rises after T_CHOLD more, and `ras_n` rises once it has been low for T_RAS clocks. `req` falls, or the next refresh starts, T_RP clocks after that.

The bench counts rising edges since reset and samples on the falling edge. It puts every expected start cycle into a queue in advance. A monitor pops one entry at each observed `cas_n` fall and measures each strobe phase in whole clocks. The grant changes are placed so that no slot tick lands inside a catch-up run. This keeps each start time exact.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_BOTH,
    PH_RASONLY,
    PH_PRECH
  } phase_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/cbr_interval_timer.sv
module cbr_interval_timer #(
  parameter int INTERVAL = 1953
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick  <= (cnt_q == LAST);
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  // a slot pulse is always seen right after the counter wrapped
  assert_tick_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    tick |-> (cnt_q == '0));

endmodule

// File: rtl/cbr_owed_counter.sv
module cbr_owed_counter #(
  parameter int MAX_OWED = 8,
  localparam int OW = $clog2(MAX_OWED + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic done,
  output logic pending_next
);
  localparam logic [OW-1:0] CAP = OW'(MAX_OWED);

  logic [OW-1:0] owed_q, owed_d;

  always_comb begin
    owed_d = owed_q;
    unique case ({tick, done})
      2'b10:   owed_d = (owed_q == CAP) ? owed_q : owed_q + 1'b1;
      2'b01:   owed_d = (owed_q == '0) ? owed_q : owed_q - 1'b1;
      default: owed_d = owed_q;
    endcase
  end

  assign pending_next = (owed_d != '0);

  always_ff @(posedge clk) begin
    if (rst) owed_q <= '0;
    else     owed_q <= owed_d;
  end

  assert_owed_bound_R8: assert property (@(posedge clk) disable iff (rst)
    owed_q <= CAP);

  assert_owed_sat_R8: assert property (@(posedge clk) disable iff (rst)
    (owed_q == CAP && tick && !done) |=> (owed_q == CAP));

endmodule

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
  import cbr_pkg::*;
#(
  parameter int T_SETUP = 2,
  parameter int T_CHOLD = 4,
  parameter int T_RAS   = 8,
  parameter int T_RP    = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic grant,
  input  logic pending_next,
  output logic done,
  output logic req,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic oe_n
);
  localparam int PW = $clog2(max3(T_SETUP, T_RAS, T_RP) + 1);
  localparam logic [PW-1:0] L_SETUP = PW'(T_SETUP - 1);
  localparam logic [PW-1:0] L_BOTH  = PW'(T_CHOLD - 1);
  localparam logic [PW-1:0] L_RONLY = PW'(T_RAS - T_CHOLD - 1);
  localparam logic [PW-1:0] L_PRE   = PW'(T_RP - 1);
  localparam int RW = $clog2(T_RAS + 2);
  localparam int HW = $clog2(T_RP + 2);

  phase_e st_q, st_d;
  logic [PW-1:0] ph_cnt;

  always_comb begin
    st_d = st_q;
    done = 1'b0;
    unique case (st_q)
      PH_IDLE:    if (req && grant)      st_d = PH_SETUP;
      PH_SETUP:   if (ph_cnt == L_SETUP) st_d = PH_BOTH;
      PH_BOTH:    if (ph_cnt == L_BOTH)  st_d = PH_RASONLY;
      PH_RASONLY: if (ph_cnt == L_RONLY) st_d = PH_PRECH;
      PH_PRECH: begin
        if (ph_cnt == L_PRE) begin
          done = 1'b1;
          st_d = (grant && pending_next) ? PH_SETUP : PH_IDLE;
        end
      end
      default: st_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PH_IDLE;
      ph_cnt <= '0;
      req    <= 1'b0;
      ras_n  <= 1'b1;
      cas_n  <= 1'b1;
      we_n   <= 1'b1;
      oe_n   <= 1'b1;
    end else begin
      st_q   <= st_d;
      ph_cnt <= (st_d != st_q || st_d == PH_IDLE) ? '0 : ph_cnt + 1'b1;
      ras_n  <= !(st_d == PH_BOTH || st_d == PH_RASONLY);
      cas_n  <= !(st_d == PH_SETUP || st_d == PH_BOTH);
      req    <= (st_d != PH_IDLE) || pending_next;
      we_n   <= 1'b1;
      oe_n   <= 1'b1;
    end
  end

  // run-length trackers used only by the checks below
  logic [RW-1:0] ras_run;
  logic [HW-1:0] hi_run;
  always_ff @(posedge clk) begin
    if (rst) begin
      ras_run <= '0;
      hi_run  <= HW'(T_RP);
    end else begin
      ras_run <= ras_n ? '0 : ras_run + 1'b1;
      if (!(ras_n && cas_n))  hi_run <= '0;
      else if (hi_run < HW'(T_RP)) hi_run <= hi_run + 1'b1;
    end
  end

  assert_cas_first_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

  assert_ras_width_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> (ras_run == RW'(T_RAS)));

  assert_precharge_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(cas_n) |-> (hi_run >= HW'(T_RP)));

  assert_bus_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    we_n && oe_n);

  assert_req_covers_R3: assert property (@(posedge clk) disable iff (rst)
    (!ras_n || !cas_n) |-> req);

endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched #(
  parameter int INTERVAL = 1953,
  parameter int MAX_OWED = 8,
  parameter int T_SETUP  = 2,
  parameter int T_CHOLD  = 4,
  parameter int T_RAS    = 8,
  parameter int T_RP     = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic grant,
  output logic req,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic oe_n
);
  logic tick;
  logic done;
  logic pending_next;

  cbr_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  cbr_owed_counter #(.MAX_OWED(MAX_OWED)) u_owed (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .done         (done),
    .pending_next (pending_next)
  );

  cbr_strobe_seq #(
    .T_SETUP (T_SETUP),
    .T_CHOLD (T_CHOLD),
    .T_RAS   (T_RAS),
    .T_RP    (T_RP)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .grant        (grant),
    .pending_next (pending_next),
    .done         (done),
    .req          (req),
    .ras_n        (ras_n),
    .cas_n        (cas_n),
    .we_n         (we_n),
    .oe_n         (oe_n)
  );

endmodule

// File: tb/cbr_refresh_sched_test.sv
`timescale 1ns/1ps
module cbr_refresh_sched_test;
  localparam int INTERVAL = 100;
  localparam int MAX_OWED = 8;
  localparam int T_SETUP  = 2;
  localparam int T_CHOLD  = 3;
  localparam int T_RAS    = 6;
  localparam int T_RP     = 3;
  localparam int SPAN     = T_SETUP + T_RAS + T_RP;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic grant = 1'b0;
  logic req, ras_n, cas_n, we_n, oe_n;

  cbr_refresh_sched #(
    .INTERVAL(INTERVAL), .MAX_OWED(MAX_OWED), .T_SETUP(T_SETUP),
    .T_CHOLD(T_CHOLD), .T_RAS(T_RAS), .T_RP(T_RP)
  ) uut (
    .clk(clk), .rst(rst), .grant(grant), .req(req),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  int n_cmp = 0;
  int n_bad = 0;
  int exp_q[$];
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, expv);
    end
  endtask

  task automatic expect_start(input int c);
    exp_q.push_back(c);
  endtask

  task automatic at_cycle(input int n);
    while (cyc != n) @(negedge clk);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitor: pops expected refresh starts and measures strobe phases
  bit prev_ras = 1'b1, prev_cas = 1'b1;
  int sl = 0, bl = 0, rl = 0, last_rise = -1;
  always @(negedge clk) begin
    if (!rst) begin
      check(we_n && oe_n, "R7 we_n/oe_n", {we_n, oe_n}, 3);
      if (prev_cas && !cas_n) begin
        check(ras_n, "R4 cas leads ras", ras_n, 1);
        if (exp_q.size() == 0) check(1'b0, "R2 unexpected refresh", cyc, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(cyc == e, "R2/R9 refresh start", cyc, e);
        end
        if (last_rise >= 0) check(cyc - last_rise >= T_RP, "R6 precharge gap", cyc - last_rise, T_RP);
        sl = 0; bl = 0; rl = 0;
      end
      if (prev_ras && !ras_n && cas_n) check(1'b0, "R4 ras fell with cas high", cas_n, 0);
      if (!cas_n && ras_n)  sl++;
      if (!cas_n && !ras_n) bl++;
      if (cas_n && !ras_n)  rl++;
      if (!prev_ras && ras_n) begin
        check(sl == T_SETUP, "R4 cas setup", sl, T_SETUP);
        check(bl == T_CHOLD, "R5 cas hold", bl, T_CHOLD);
        check(bl + rl == T_RAS, "R5 ras width", bl + rl, T_RAS);
        last_rise = cyc;
      end
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  // driver
  initial begin
    grant = 1'b1;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check({req, ras_n, cas_n, we_n, oe_n} == 5'b01111, "R1 reset state",
          {req, ras_n, cas_n, we_n, oe_n}, 5'b01111);
    expect_start(INTERVAL + 2);
    expect_start(2 * INTERVAL + 2);
    for (int j = 0; j < 5; j++) expect_start(706 + j * SPAN);
    expect_start(8 * INTERVAL + 2);
    for (int j = 0; j < MAX_OWED; j++) expect_start(2110 + j * SPAN);
    expect_start(22 * INTERVAL + 2);
    expect_start(23 * INTERVAL + 2);
    rst = 1'b0;

    at_cycle(112); check(req == 1'b1, "R3 req held to end", req, 1);
    at_cycle(113); check(req == 1'b0, "R6 req drops after precharge", req, 0);
    at_cycle(205); grant = 1'b0;
    at_cycle(208);
    check(req == 1'b1, "R10 req kept after grant drop", req, 1);
    check(ras_n == 1'b0, "R10 ras still low", ras_n, 0);
    at_cycle(700); check(req == 1'b1, "R9 req while owed", req, 1);
    at_cycle(705); grant = 1'b1;
    at_cycle(820); grant = 1'b0;
    at_cycle(2109); check(req == 1'b1, "R8 req while saturated", req, 1);
    grant = 1'b1;
    at_cycle(2199); check(req == 1'b0, "R8 backlog capped", req, 0);
    at_cycle(2350); check(exp_q.size() == 0, "R8 all starts seen", exp_q.size(), 0);
    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL R2 watchdog expired: actual %0d expected %0d", cyc, 2350);
      report();
      $finish;
    end
  end

endmodule